// File: doc/BRIEF.md
# Duty-Cycled Supply Monitor Controller

This block drives an external supply comparator that flags when the supply has fallen below a programmed threshold. It can keep the comparator on at all times, or power it for a single slow-clock period out of every 32, 256 or 2048 periods to save energy. The block registers the comparator verdict at the close of each powered period. A verdict of "below" is a detection.

Each detection sets a sticky history flag. It can also raise an interrupt, request a core reset and request a wake-up. Each of these three actions has its own enable. Reading the status word clears the sticky flags. A word-wide register bus with separate write and read strobes sets the configuration. The 4-bit threshold code goes straight out to the analog side.

Top module: `smon_ctrl`

## Requirements
- R1: After reset, every output is 0, and reads of the configuration word (address 0) and the status word (address 1) both return 0.
- R2: With sampling code 0 in configuration bits 10:8, `cmp_en_o` stays low and no detection occurs, even while `cmp_below_i` is 1.
- R3: With sampling code 1, `cmp_en_o` goes high on the second clock edge after the configuration write and stays high. Every clock edge then samples the comparator.
- R4: With sampling codes 2, 3 and 4, `cmp_en_o` is high for exactly one cycle in every 32, 256 and 2048 cycles respectively. The first such cycle starts N edges after the configuration write edge, and `cmp_en_o` is never high for two cycles in a row.
- R5: `level_low_o` (status bit 0) takes the value of `cmp_below_i` at the clock edge that ends a cycle with `cmp_en_o` high. At all other edges it holds its value.
- R6: A detection (comparator enabled and reporting below) sets `det_status_o` (status bit 1). A read of the status word returns the flags as they were before the read and clears them.
- R7: When configuration bit 12 is set, a detection gives a one-cycle `reset_req_o` pulse and sets the reset-history flag (status bit 2). When bit 12 is clear, neither happens.
- R8: When configuration bit 13 is set, `irq_o` is high while the detection flag is set. When bit 13 is clear, `irq_o` stays low.
- R9: When configuration bit 14 is set, a detection gives a one-cycle `wake_req_o` pulse and sets the wake-history flag (status bit 3). When bit 14 is clear, neither happens.
- R10: If a detection and a status read fall on the same edge, the detection wins and the flag stays set.
- R11: `thr_o` follows configuration bits 3:0. Sampling codes 5 to 7 behave like code 0.
- R12: A configuration read returns only the defined fields (bits 14:12, 10:8 and 3:0) and all other bits read 0. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | AW | Word address (0 configuration, 1 status) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered on the read edge |
| cmp_below_i | input | 1 | Comparator verdict, 1 = supply below threshold |
| cmp_en_o | output | 1 | Comparator power enable |
| thr_o | output | 4 | Threshold code passed to the comparator |
| level_low_o | output | 1 | Result of the last measurement |
| det_status_o | output | 1 | Sticky detection flag |
| irq_o | output | 1 | Interrupt request |
| reset_req_o | output | 1 | Core reset request pulse |
| wake_req_o | output | 1 | Wake-up request pulse |

## Verification
A schedule counter that is out of step shows up at once on `cmp_en_o`: the pulse lands on the wrong cycle, or two pulses arrive back to back. The bench counts the exact cycle of the first and second pulse in each periodic mode. A corrupt sample register shows on `level_low_o` on the edge that follows a powered cycle. A wrong sticky flag shows on the next status read, through the returned word, and through `det_status_o` and `irq_o`. The read-versus-detection collision is placed on one exact edge, so a wrong priority is seen in the very next cycle.

// File: rtl/smon_pkg.sv
package smon_pkg;
  localparam logic [2:0] SMP_OFF  = 3'd0;
  localparam logic [2:0] SMP_CONT = 3'd1;
  localparam logic [2:0] SMP_DA   = 3'd2;
  localparam logic [2:0] SMP_DB   = 3'd3;
  localparam logic [2:0] SMP_DC   = 3'd4;

  // configuration word field positions
  localparam int THR_LSB   = 0;
  localparam int SMP_LSB   = 8;
  localparam int RSTEN_BIT = 12;
  localparam int IRQEN_BIT = 13;
  localparam int WAKEN_BIT = 14;

  // status word bit positions
  localparam int ST_LEVEL = 0;
  localparam int ST_DET   = 1;
  localparam int ST_RST   = 2;
  localparam int ST_WAKE  = 3;

  typedef struct packed {
    logic       wake_en;
    logic       irq_en;
    logic       rst_en;
    logic [2:0] smp;
    logic [3:0] thr;
  } smon_cfg_t;
endpackage

// File: rtl/smon_sched.sv
module smon_sched #(
  parameter int DIV_A = 32,
  parameter int DIV_B = 256,
  parameter int DIV_C = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [2:0] smp,
  output logic       cmp_en_o
);
  import smon_pkg::*;

  localparam int MAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int MAXD   = (MAX_AB > DIV_C) ? MAX_AB : DIV_C;
  localparam int CW     = (MAXD > 2) ? $clog2(MAXD) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          periodic;
  logic          wrap;

  always_comb begin
    periodic = 1'b1;
    lim      = '0;
    case (smp)
      SMP_DA:  lim = CW'(DIV_A - 1);
      SMP_DB:  lim = CW'(DIV_B - 1);
      SMP_DC:  lim = CW'(DIV_C - 1);
      default: periodic = 1'b0;
    endcase
  end

  assign wrap = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt      <= '0;
      cmp_en_o <= 1'b0;
    end else begin
      cmp_en_o <= (smp == SMP_CONT) || (periodic && wrap);
      cnt      <= (!periodic || wrap) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/smon_status.sv
module smon_status (
  input  logic clk,
  input  logic rst,
  input  logic cmp_en,
  input  logic below,
  input  logic clr,
  input  logic rst_en,
  input  logic irq_en,
  input  logic wake_en,
  output logic level_q,
  output logic det_q,
  output logic rstst_q,
  output logic wakest_q,
  output logic irq_q,
  output logic rreq_q,
  output logic wreq_q
);
  logic hit;
  logic det_n;
  logic rstst_n;
  logic wakest_n;

  assign hit      = cmp_en & below;
  assign det_n    = hit | (det_q & ~clr);
  assign rstst_n  = (hit & rst_en) | (rstst_q & ~clr);
  assign wakest_n = (hit & wake_en) | (wakest_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q  <= 1'b0;
      det_q    <= 1'b0;
      rstst_q  <= 1'b0;
      wakest_q <= 1'b0;
      irq_q    <= 1'b0;
      rreq_q   <= 1'b0;
      wreq_q   <= 1'b0;
    end else begin
      if (cmp_en) level_q <= below;
      det_q    <= det_n;
      rstst_q  <= rstst_n;
      wakest_q <= wakest_n;
      irq_q    <= irq_en & det_n;
      rreq_q   <= hit & rst_en;
      wreq_q   <= hit & wake_en;
    end
  end
endmodule

// File: rtl/smon_ctrl.sv
module smon_ctrl #(
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int DIV_A = 32,
  parameter int DIV_B = 256,
  parameter int DIV_C = 2048
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          cmp_below_i,
  output logic          cmp_en_o,
  output logic [3:0]    thr_o,
  output logic          level_low_o,
  output logic          det_status_o,
  output logic          irq_o,
  output logic          reset_req_o,
  output logic          wake_req_o
);
  import smon_pkg::*;

  localparam logic [AW-1:0] CFG_ADDR  = AW'(0);
  localparam logic [AW-1:0] STAT_ADDR = AW'(1);

  smon_cfg_t     cfg_q;
  logic          cfg_wr;
  logic          stat_rd;
  logic [2:0]    smp_w;
  logic          rstst;
  logic          wakest;
  logic [DW-1:0] rd_v;
  logic          unused_wdata_bits;

  assign cfg_wr  = bus_we && (bus_addr == CFG_ADDR);
  assign stat_rd = bus_re && (bus_addr == STAT_ADDR);
  assign smp_w   = cfg_q.smp;
  assign thr_o   = cfg_q.thr;
  assign unused_wdata_bits = ^{bus_wdata[DW-1:15], bus_wdata[11], bus_wdata[7:4]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (cfg_wr) begin
      cfg_q.thr     <= bus_wdata[THR_LSB +: 4];
      cfg_q.smp     <= bus_wdata[SMP_LSB +: 3];
      cfg_q.rst_en  <= bus_wdata[RSTEN_BIT];
      cfg_q.irq_en  <= bus_wdata[IRQEN_BIT];
      cfg_q.wake_en <= bus_wdata[WAKEN_BIT];
    end
  end

  smon_sched #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_sched (
    .clk      (clk),
    .rst      (rst),
    .restart  (cfg_wr),
    .smp      (smp_w),
    .cmp_en_o (cmp_en_o)
  );

  smon_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .cmp_en   (cmp_en_o),
    .below    (cmp_below_i),
    .clr      (stat_rd),
    .rst_en   (cfg_q.rst_en),
    .irq_en   (cfg_q.irq_en),
    .wake_en  (cfg_q.wake_en),
    .level_q  (level_low_o),
    .det_q    (det_status_o),
    .rstst_q  (rstst),
    .wakest_q (wakest),
    .irq_q    (irq_o),
    .rreq_q   (reset_req_o),
    .wreq_q   (wake_req_o)
  );

  always_comb begin
    rd_v = '0;
    if (bus_addr == CFG_ADDR) begin
      rd_v[THR_LSB +: 4] = cfg_q.thr;
      rd_v[SMP_LSB +: 3] = cfg_q.smp;
      rd_v[RSTEN_BIT]    = cfg_q.rst_en;
      rd_v[IRQEN_BIT]    = cfg_q.irq_en;
      rd_v[WAKEN_BIT]    = cfg_q.wake_en;
    end else if (bus_addr == STAT_ADDR) begin
      rd_v[ST_LEVEL] = level_low_o;
      rd_v[ST_DET]   = det_status_o;
      rd_v[ST_RST]   = rstst;
      rd_v[ST_WAKE]  = wakest;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_v;
  end
endmodule

// File: rtl/smon_ctrl_chk.sv
module smon_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmp_en,
  input logic       below,
  input logic       level,
  input logic       det,
  input logic       irq,
  input logic       rreq,
  input logic       wreq,
  input logic [2:0] smp
);
  // R2
  off_no_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (smp == 3'd0 || smp > 3'd4) |-> !cmp_en);

  // R4
  no_double_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && $past(cmp_en)) |-> (smp == 3'd1));

  // R5
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cmp_en) |-> $stable(level));

  // R6
  det_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(det) |-> $past(cmp_en && below));

  // R10
  det_wins_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cmp_en && below) |-> det);

  // R7
  rreq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rreq |-> $past(cmp_en && below));

  // R8
  irq_needs_det_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> det);

  // R9
  wreq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    wreq |-> $past(cmp_en && below));
endmodule

bind smon_ctrl smon_ctrl_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .cmp_en (cmp_en_o),
  .below  (cmp_below_i),
  .level  (level_low_o),
  .det    (det_status_o),
  .irq    (irq_o),
  .rreq   (reset_req_o),
  .wreq   (wake_req_o),
  .smp    (smp_w)
);

// File: tb/smon_ctrl_tb.sv
module smon_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          cmp_below_i = 1'b0;
  logic          cmp_en_o;
  logic [3:0]    thr_o;
  logic          level_low_o;
  logic          det_status_o;
  logic          irq_o;
  logic          reset_req_o;
  logic          wake_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smon_ctrl #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_below_i(cmp_below_i), .cmp_en_o(cmp_en_o), .thr_o(thr_o),
    .level_low_o(level_low_o), .det_status_o(det_status_o), .irq_o(irq_o),
    .reset_req_o(reset_req_o), .wake_req_o(wake_req_o)
  );

  function automatic logic [DW-1:0] mkcfg(int smp, int thr, bit r, bit i, bit w);
    return DW'((int'(w) << 14) | (int'(i) << 13) | (int'(r) << 12) | (smp << 8) | thr);
  endfunction

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(int addr, logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int addr, output logic [DW-1:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = AW'(addr);
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic clean();
    logic [DW-1:0] d;
    cmp_below_i = 1'b0;
    wr(0, '0);
    rd(1, d);
  endtask

  // one-cycle low reading on continuous mode: returns at negedge after the sample
  task automatic pulse_low_cont(logic [DW-1:0] cfg);
    wr(0, cfg);
    @(negedge clk);
    cmp_below_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R1 outputs", {cmp_en_o, thr_o, level_low_o, det_status_o, irq_o, reset_req_o, wake_req_o}, '0);
    rd(0, d); check("R1 cfg read", d, '0);
    rd(1, d); check("R1 status read", d, '0);
  endtask

  task automatic t_disabled();
    int en_cnt = 0;
    clean();
    wr(0, mkcfg(0, 3, 1, 1, 1));
    cmp_below_i = 1'b1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (cmp_en_o) en_cnt++;
    end
    check("R2 no enable", DW'(en_cnt), '0);
    check("R2 no detection", {det_status_o, irq_o, reset_req_o, wake_req_o}, '0);
    cmp_below_i = 1'b0;
  endtask

  task automatic t_continuous();
    int on_cnt = 0;
    clean();
    wr(0, mkcfg(1, 0, 0, 0, 0));
    check("R3 off right after write", cmp_en_o, 0);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (cmp_en_o) on_cnt++;
    end
    check("R3 always on", DW'(on_cnt), 10);
    cmp_below_i = 1'b1;
    @(negedge clk);
    check("R3 sampled every edge", {level_low_o, det_status_o}, 2'b11);
    cmp_below_i = 1'b0;
    @(negedge clk);
    check("R3 next sample", level_low_o, 0);
  endtask

  task automatic t_periodic(int code, int n);
    int hits = 0;
    int first = 0;
    int second = 0;
    clean();
    wr(0, mkcfg(code, 0, 0, 0, 0));
    for (int k = 1; k <= 2*n + 1; k++) begin
      @(negedge clk);
      if (cmp_en_o) begin
        hits++;
        if (hits == 1) first = k;
        if (hits == 2) second = k;
      end
    end
    check($sformatf("R4 pulse count code %0d", code), DW'(hits), 2);
    check($sformatf("R4 first pulse code %0d", code), DW'(first), DW'(n));
    check($sformatf("R4 second pulse code %0d", code), DW'(second), DW'(2*n));
  endtask

  task automatic t_hold();
    clean();
    wr(0, mkcfg(2, 0, 0, 0, 0));
    for (int k = 1; k <= 64; k++) begin
      @(negedge clk);
      if (k == 34) cmp_below_i = 1'b1;
    end
    check("R5 held while unpowered", level_low_o, 0);
    check("R5 pulse at 64", cmp_en_o, 1);
    @(negedge clk);
    check("R5 sampled at end of powered cycle", {level_low_o, det_status_o}, 2'b11);
    cmp_below_i = 1'b0;
  endtask

  task automatic t_clear_on_read();
    logic [DW-1:0] d;
    clean();
    pulse_low_cont(mkcfg(1, 0, 0, 0, 0));
    cmp_below_i = 1'b0;
    check("R6 flag set", det_status_o, 1);
    wr(0, '0);
    rd(1, d);
    check("R6 read shows flag", d[1], 1);
    check("R6 cleared by read", det_status_o, 0);
    rd(1, d);
    check("R6 second read clear", d, '0);
  endtask

  task automatic t_reset_req();
    logic [DW-1:0] d;
    clean();
    pulse_low_cont(mkcfg(1, 0, 1, 0, 0));
    cmp_below_i = 1'b0;
    check("R7 reset pulse", reset_req_o, 1);
    @(negedge clk);
    check("R7 pulse one cycle", reset_req_o, 0);
    wr(0, '0);
    rd(1, d);
    check("R7 reset history", d[3:1], 3'b011);
    clean();
    pulse_low_cont(mkcfg(1, 0, 0, 0, 0));
    cmp_below_i = 1'b0;
    check("R7 no pulse when disabled", reset_req_o, 0);
    wr(0, '0);
    rd(1, d);
    check("R7 no history when disabled", d[3:1], 3'b001);
  endtask

  task automatic t_irq();
    logic [DW-1:0] d;
    clean();
    pulse_low_cont(mkcfg(1, 0, 0, 1, 0));
    cmp_below_i = 1'b0;
    check("R8 irq raised", irq_o, 1);
    wr(0, mkcfg(0, 0, 0, 1, 0));
    repeat (3) @(negedge clk);
    check("R8 irq level held", irq_o, 1);
    rd(1, d);
    check("R8 irq cleared with flag", irq_o, 0);
    clean();
    pulse_low_cont(mkcfg(1, 0, 0, 0, 0));
    cmp_below_i = 1'b0;
    @(negedge clk);
    check("R8 masked irq", {irq_o, det_status_o}, 2'b01);
  endtask

  task automatic t_wake();
    logic [DW-1:0] d;
    clean();
    pulse_low_cont(mkcfg(1, 0, 0, 0, 1));
    cmp_below_i = 1'b0;
    check("R9 wake pulse", {wake_req_o, reset_req_o}, 2'b10);
    @(negedge clk);
    check("R9 pulse one cycle", wake_req_o, 0);
    wr(0, '0);
    rd(1, d);
    check("R9 wake history", d[3:1], 3'b101);
    clean();
    pulse_low_cont(mkcfg(1, 0, 0, 0, 0));
    cmp_below_i = 1'b0;
    check("R9 no wake when disabled", wake_req_o, 0);
  endtask

  task automatic t_race();
    logic [DW-1:0] d;
    clean();
    wr(0, mkcfg(2, 0, 0, 0, 0));
    cmp_below_i = 1'b1;
    for (int k = 1; k <= 31; k++) @(negedge clk);
    rd(1, d);
    check("R10 pre-read value", d[1], 0);
    check("R10 detection wins", det_status_o, 1);
    cmp_below_i = 1'b0;
  endtask

  task automatic t_regs();
    logic [DW-1:0] d;
    int en_cnt = 0;
    clean();
    wr(0, mkcfg(5, 4'hA, 1, 0, 1));
    check("R11 threshold out", DW'(thr_o), 32'hA);
    rd(0, d);
    check("R12 cfg readback", d, 32'h0000_550A);
    cmp_below_i = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (cmp_en_o) en_cnt++;
    end
    check("R11 reserved code disabled", {DW'(en_cnt)}, '0);
    check("R11 no detection", det_status_o, 0);
    cmp_below_i = 1'b0;
    wr(0, 32'hFFFF_FFFF);
    rd(0, d);
    check("R12 undefined bits read zero", d, 32'h0000_770F);
    rd(2, d);
    check("R12 unmapped address", d, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_continuous();
    t_periodic(2, 32);
    t_periodic(3, 256);
    t_periodic(4, 2048);
    t_hold();
    t_clear_on_read();
    t_reset_req();
    t_irq();
    t_wake();
    t_race();
    t_regs();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule